// File: doc/BRIEF.md
# Two-Stage 4x Halfband Interpolator

This block raises the sample rate of a 14-bit two's-complement stream by a factor of four. It does this with two 2x halfband lowpass stages in cascade. Everything runs on one clock at the output rate. A free-running two-bit phase counter marks the input word instants and the intermediate 2x instants. The upstream source watches `word_strobe` and offers a new word on `din` while that strobe is high. The block then emits one filtered output word on every clock.

Each stage is built in polyphase form. The even output phase is a pure delay of the centre tap, so input words pass through unchanged. The odd phase is a short symmetric FIR with integer coefficients whose sum equals the scale factor, which gives unity gain at DC. Odd-phase sums are rounded to nearest and clamped to the 14-bit range. A zero-filled delay line after the second stage pads the path so that the total delay is exactly 95 output clocks, which is 23¾ input-word periods.

Top module: `hb_interp4x`

## Requirements
- R1: `word_strobe` is high for one clock in every four, and the first clock edge after reset release is a capture edge. `din` is registered on every edge at which `word_strobe` was high, and the word captured at the q-th such edge is x[q], counting from q = 0.
- R2: The output stream t[j] advances by one index per clock. Every fourth sample reproduces the input exactly, t[4q] = x[q].
- R3: The word captured at edge c appears on `dout` right after edge c+95 and is held for one clock.
- R4: The first stage produces s[2q] = x[q] and s[2q+1] = sat((3·x[q-2] − 25·x[q-1] + 150·x[q] + 150·x[q+1] − 25·x[q+2] + 3·x[q+3] + 128) >>> 8). Then t[4q+2] = s[2q+1].
- R5: The second stage produces t[2p] = s[p] and t[2p+1] = sat((−s[p-1] + 9·s[p] + 9·s[p+1] − s[p+2] + 8) >>> 4).
- R6: sat() clamps each rounded odd-phase result to the range −8192 … 8191, so full-scale input patterns whose interpolated value overshoots are clipped at the rail and never wrap.
- R7: A constant input C settles to exactly C on every output sample.
- R8: An active-low `rst_n` clears every register asynchronously. Input history before the first capture counts as zero. `dout` stays 0 through the first 82 clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock (four times the input word rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 14 | Input word, two's complement, sampled when `word_strobe` is high |
| word_strobe | output | 1 | High during the clock whose closing edge captures `din` |
| dout | output | 14 | Interpolated output word, two's complement, one per clock |

## Verification
An isolated impulse separates the pure-delay phase from the two odd phases, and it pins the 95-clock delay to a single output sample. A held step shows that both odd phases have unity DC gain, which a wrong coefficient or rounding offset would spoil. A full-scale sine exercises the rounding across all three interpolated positions without reaching the rails. A period-three pattern at the rails then forces the first stage into overshoot, which separates clamping from wraparound. Every output clock is compared against an integer model of the same arithmetic, and the zero-history period after reset shows whether the delay lines start clean.

// File: rtl/interp_pkg.sv
package interp_pkg;

  // Position of the 4x clock inside one input word period.
  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_S1_EVEN = 2'd1,
    PH_MIDDLE  = 2'd2,
    PH_S1_ODD  = 2'd3
  } phase_t;

  // First stage: odd phase of a halfband, scaled by 2^8.
  localparam int S1_TAPS  = 6;
  localparam int S1_SHIFT = 8;
  localparam int S1_COEF [S1_TAPS] = '{3, -25, 150, 150, -25, 3};

  // Second stage: odd phase of a halfband, scaled by 2^4.
  localparam int S2_TAPS  = 4;
  localparam int S2_SHIFT = 4;
  localparam int S2_COEF [S2_TAPS] = '{-1, 9, 9, -1};

  // Accumulator headroom above the data width.
  localparam int GUARD_BITS = 10;

endpackage

// File: rtl/hb_stage.sv
module hb_stage #(
  parameter int DW    = 14,
  parameter int TAPS  = 4,
  parameter int SHIFT = 4,
  parameter int GUARD = 10,
  parameter int COEF [TAPS] = '{-1, 9, 9, -1}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 even_ld,
  input  logic                 odd_ld,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  localparam int ACC_W  = DW + GUARD;
  localparam int CENTRE = TAPS / 2;
  localparam int HALF_I = 1 << (SHIFT - 1);
  localparam int MAX_I  = (1 << (DW - 1)) - 1;
  localparam int MIN_I  = -(1 << (DW - 1));

  logic signed [DW-1:0]    tap_q [TAPS];
  logic signed [DW-1:0]    tap_d [TAPS];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scaled;
  logic signed [DW-1:0]    odd_val;
  logic signed [DW-1:0]    y_q;
  logic signed [DW-1:0]    y_d;

  // Delay line next state
  always_comb begin
    for (int k = 0; k < TAPS; k++) tap_d[k] = tap_q[k];
    if (shift_en) begin
      tap_d[0] = din;
      for (int k = 1; k < TAPS; k++) tap_d[k] = tap_q[k-1];
    end
  end

  // Symmetric odd-phase sum, round to nearest, clamp
  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      acc = acc + ACC_W'(COEF[k]) * ACC_W'(tap_q[k]);
    end
    scaled = (acc + ACC_W'(HALF_I)) >>> SHIFT;
    if (scaled > ACC_W'(MAX_I))      odd_val = DW'(MAX_I);
    else if (scaled < ACC_W'(MIN_I)) odd_val = DW'(MIN_I);
    else                             odd_val = DW'(scaled);
  end

  // Output phase select
  always_comb begin
    y_d = y_q;
    if (even_ld)     y_d = tap_q[CENTRE];
    else if (odd_ld) y_d = odd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
      y_q <= '0;
    end else begin
      for (int k = 0; k < TAPS; k++) tap_q[k] <= tap_d[k];
      y_q <= y_d;
    end
  end

  assign dout = y_q;

endmodule

// File: rtl/lat_pad.sv
module lat_pad #(
  parameter int DW    = 14,
  parameter int DEPTH = 76
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);

  logic signed [DW-1:0] pipe_q [DEPTH];
  logic signed [DW-1:0] pipe_d [DEPTH];

  always_comb begin
    pipe_d[0] = din;
    for (int k = 1; k < DEPTH; k++) pipe_d[k] = pipe_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) pipe_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) pipe_q[k] <= pipe_d[k];
    end
  end

  assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/hb_interp4x.sv
module hb_interp4x #(
  parameter int DW      = 14,
  parameter int LATENCY = 95
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] din,
  output logic                 word_strobe,
  output logic signed [DW-1:0] dout
);
  import interp_pkg::*;

  // Centre-path delay through the two stages: stage 1 centre tap after
  // S1_TAPS/2 words, one register, one shift into stage 2, S2_TAPS/2
  // half-words to its centre tap, one output register.
  localparam int INTRINSIC = 2 * S1_TAPS + S2_TAPS + 3;
  localparam int PAD       = LATENCY - INTRINSIC;

  phase_t ph_q;
  phase_t ph_d;

  logic en_capture;
  logic s1_even;
  logic s1_odd;
  logic s2_shift;
  logic s2_even;
  logic s2_odd;

  logic signed [DW-1:0] s1_out;
  logic signed [DW-1:0] s2_out;

  // Phase counter
  always_comb begin
    ph_d = phase_t'(ph_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_CAPTURE;
    else        ph_q <= ph_d;
  end

  // Clock enables
  always_comb begin
    en_capture = (ph_q == PH_CAPTURE);
    s1_even    = (ph_q == PH_S1_EVEN);
    s1_odd     = (ph_q == PH_S1_ODD);
    s2_shift   = ~ph_q[0];
    s2_even    =  ph_q[0];
    s2_odd     = ~ph_q[0];
  end

  assign word_strobe = en_capture;

  hb_stage #(
    .DW(DW), .TAPS(S1_TAPS), .SHIFT(S1_SHIFT), .GUARD(GUARD_BITS), .COEF(S1_COEF)
  ) u_stage1 (
    .clk(clk), .rst_n(rst_n),
    .shift_en(en_capture), .even_ld(s1_even), .odd_ld(s1_odd),
    .din(din), .dout(s1_out)
  );

  hb_stage #(
    .DW(DW), .TAPS(S2_TAPS), .SHIFT(S2_SHIFT), .GUARD(GUARD_BITS), .COEF(S2_COEF)
  ) u_stage2 (
    .clk(clk), .rst_n(rst_n),
    .shift_en(s2_shift), .even_ld(s2_even), .odd_ld(s2_odd),
    .din(s1_out), .dout(s2_out)
  );

  lat_pad #(.DW(DW), .DEPTH(PAD)) u_pad (
    .clk(clk), .rst_n(rst_n), .din(s2_out), .dout(dout)
  );

endmodule

// File: rtl/hb_interp4x_chk.sv
module hb_interp4x_chk #(
  parameter int DW      = 14,
  parameter int LATENCY = 95
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [DW-1:0] din,
  input logic                 word_strobe,
  input logic signed [DW-1:0] dout
);

  localparam int RUN_MIN   = 30;  // equal captures spanning > latency + filter reach
  localparam int QUIET_END = 82;  // edges after release with zero output
  localparam int CNT_W     = 8;

  logic                 stb_hist [LATENCY];
  logic signed [DW-1:0] din_hist [LATENCY];
  logic [CNT_W-1:0]     run_cnt;
  logic signed [DW-1:0] last_cap;
  logic [CNT_W-1:0]     since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LATENCY; k++) begin
        stb_hist[k] <= 1'b0;
        din_hist[k] <= '0;
      end
      run_cnt   <= CNT_W'(RUN_MIN);
      last_cap  <= '0;
      since_rst <= '0;
    end else begin
      stb_hist[0] <= word_strobe;
      din_hist[0] <= din;
      for (int k = 1; k < LATENCY; k++) begin
        stb_hist[k] <= stb_hist[k-1];
        din_hist[k] <= din_hist[k-1];
      end
      if (word_strobe) begin
        last_cap <= din;
        if (din != last_cap)                  run_cnt <= '0;
        else if (run_cnt < CNT_W'(RUN_MIN))   run_cnt <= run_cnt + 1'b1;
      end
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
    end
  end

  // R1
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |=> !word_strobe ##1 !word_strobe ##1 !word_strobe ##1 word_strobe);

  // R3
  centre_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_hist[LATENCY-1] |=> (dout == $past(din_hist[LATENCY-1])));

  // R7
  dc_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= CNT_W'(RUN_MIN)) |-> (dout == last_cap));

  // R8
  reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CNT_W'(QUIET_END)) |-> (dout == '0));

endmodule

bind hb_interp4x hb_interp4x_chk #(.DW(DW), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .word_strobe(word_strobe), .dout(dout)
);

// File: tb/hb_interp4x_tb.sv
`timescale 1ns/1ps
module hb_interp4x_tb;

  localparam int DW      = 14;
  localparam int LAT     = 95;
  localparam int NCAPMAX = 2048;
  localparam int NEDGE   = 1350;
  localparam int PMAX    = 8191;
  localparam int PMIN    = -8192;

  logic                 clk;
  logic                 rst_n;
  logic signed [DW-1:0] din;
  logic                 word_strobe;
  logic signed [DW-1:0] dout;

  int xs [NCAPMAX];
  int ncap;
  int n_checks;
  int n_fail;
  int rail_hits;
  bit done;

  hb_interp4x #(.DW(DW), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .word_strobe(word_strobe), .dout(dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic int sat(int v);
    if (v > PMAX) return PMAX;
    if (v < PMIN) return PMIN;
    return v;
  endfunction

  function automatic int xm(int n);
    if (n < 0 || n >= ncap) return 0;
    return xs[n];
  endfunction

  function automatic int s1m(int m);
    int q;
    int acc;
    q = m >>> 1;
    if ((m & 1) == 0) return xm(q);
    acc = 3*xm(q-2) - 25*xm(q-1) + 150*xm(q) + 150*xm(q+1) - 25*xm(q+2) + 3*xm(q+3);
    return sat((acc + 128) >>> 8);
  endfunction

  function automatic int tm(int j);
    int p;
    int acc;
    p = j >>> 1;
    if ((j & 1) == 0) return s1m(p);
    acc = -s1m(p-1) + 9*s1m(p) + 9*s1m(p+1) - s1m(p+2);
    return sat((acc + 8) >>> 4);
  endfunction

  function automatic int stim(int q);
    if (q == 10) return 4000;
    if (q >= 40 && q < 80) return 3000;
    if (q == 95) return -8192;
    if (q >= 120 && q < 220) return $rtoi(8191.0 * $sin(2.0 * 3.14159265358979 * 0.11 * q));
    if (q >= 220 && q < 260) return ((q % 3) == 1) ? PMIN : PMAX;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // ---------------- stimulus and comparison ----------------
  initial begin
    int a;
    int ex;
    string tag;
    rst_n = 1'b0;
    din = '0;
    ncap = 0;
    n_checks = 0;
    n_fail = 0;
    rail_hits = 0;
    done = 1'b0;
    repeat (3) @(negedge clk);
    a = dout;
    check(dout == '0, "R8 reset value", a, 0);
    rst_n = 1'b1;

    for (int e = 0; e < NEDGE; e++) begin
      if (word_strobe) begin
        din = DW'(stim(ncap));
        xs[ncap] = stim(ncap);
        ncap++;
      end
      @(posedge clk);
      @(negedge clk);
      a  = dout;
      ex = tm(e - LAT);
      if (e < 82)                       tag = "R8 quiet start";
      else if (ex == PMAX || ex == PMIN) tag = "R6 rail clamp";
      else if (((e - LAT) & 3) == 0)    tag = "R2 centre sample";
      else if (((e - LAT) & 3) == 2)    tag = "R4 stage1 odd";
      else                              tag = "R5 stage2 odd";
      check(a == ex, tag, a, ex);
      if (e < 82) check(a == 0, "R8 zero before fill", a, 0);
      check(word_strobe == (((e + 1) % 4) == 0), "R1 strobe phase",
            int'(word_strobe), int'(((e + 1) % 4) == 0));
      if (e == 135) check(a == 4000, "R3 impulse at edge 135", a, 4000);
      if (e >= 372 && e <= 375) check(a == 3000, "R7 settled step", a, 3000);
      if (e >= 975 && e <= 1131 && a == PMAX) rail_hits++;
    end
    check(rail_hits > 0, "R6 positive rail reached", rail_hits, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule